// File: doc/BRIEF.md
# TDM Time-Slot Assigner

The assigner splits a serial time-division frame into consecutive slices and hands each slice to one of three serial channels, to none, and optionally to one or more strobe outputs. It walks a programmable route table from entry 0, starting on the clock that carries the frame sync, and spends one slice per entry. Each entry gives the slice length as a count stored minus one, a unit flag for single bits or 8-bit bytes, a channel code, a strobe mask and a flag that ends the frame.

One bit moves per clock. On the receive side, the serial input is registered and a one-clock enable is pulsed to the channel that owns the bit. On the transmit side, the owning channel's bit is muxed onto the serial output, and the line idles at 1 in unrouted slices. In common mode, the receive and transmit walks share the whole 16-entry table and the receive sync. Otherwise, receive uses entries 0 to 7, transmit uses entries 8 to 15, and transmit starts on its own sync.

Top module: `tdm_slot_router`

## Requirements
- R1: With `en` high, a clock with `sync` high starts a walk at the first entry of the walk's table half. That sync clock's bit is the first bit of the entry's slice, and its outputs appear one clock later.
- R2: An entry word uses these fields: bits [12:9] hold the length minus one, bit 1 is the unit flag (1 = bytes of 8 bits, 0 = single bits), bit 0 is the last-entry flag, and bits [15:13] are ignored. The walk moves to the next entry after (length+1) units.
- R3: Entry bits [8:6] select the channel. Code 3'b010 selects channel 0, 3'b011 selects channel 1, 3'b101 selects channel 2, and every other code selects none. `rx_valid[c]` pulses for one clock per bit routed to channel c, with `rx_data` holding the `rxd` value sampled on the same edge. At most one `rx_valid` bit is high at a time.
- R4: Entry bits [5:2] are a strobe mask. `strobe[k]` is high for each bit of a slice whose mask bit k is set, whether or not a channel is routed to the slice.
- R5: After the final bit of an entry with the last-entry flag, no valid, take or strobe is raised until the next sync.
- R6: A sync that arrives while a walk is still in progress restarts the walk at its first entry and sets `sync_error`. The flag stays set until reset.
- R7: `tx_bit` carries the `tx_din` bit of the channel routed to the current transmit slice, sampled on the same edge that `tx_take` pulses for that channel. `tx_bit` is 1 when no channel is routed.
- R8: With `common_mode` = 1, the transmit walk uses entries 0 to 15 and `sync`. With `common_mode` = 0, receive uses entries 0 to 7 and `sync`, transmit uses entries 8 to 15 and `tx_sync`, and each walk wraps within its own half.
- R9: A table write (`wr_en`, `wr_addr`, `wr_data`) takes effect only while `en` is low. A write while `en` is high is ignored.
- R10: After reset, `rx_valid`, `tx_take`, `strobe`, `rx_data` and `sync_error` are 0 and `tx_bit` is 1.
- R11: One clock after `en` is low, `rx_valid`, `tx_take` and `strobe` are 0, and any walk in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Assigner enable; table writable only when low |
| common_mode | input | 1 | 1: shared table and sync for both directions |
| sync | input | 1 | Frame sync (receive, or both in common mode) |
| tx_sync | input | 1 | Transmit frame sync in split mode |
| rxd | input | 1 | Serial receive data |
| tx_din | input | 3 | Transmit bit offered by each channel |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 4 | Table write address |
| wr_data | input | 16 | Table write word |
| rx_data | output | 1 | Registered receive bit |
| rx_valid | output | 3 | Per-channel receive bit enable |
| tx_bit | output | 1 | Serial transmit data |
| tx_take | output | 3 | Per-channel transmit bit consumed |
| strobe | output | 4 | Slice strobes |
| sync_error | output | 1 | Sticky early-sync flag |

## Verification
The hardest situations to reach from the ports are a sync landing inside a long byte slice, and a split-mode frame whose two walks sit at unrelated offsets while the table keeps changing. The bench reaches them by directed frames first: the shared example frame, an early sync, a write attempted while enabled, and split halves with a two-byte slice. It then runs a long stretch with random table words (rewritten only during disabled gaps), sparse random syncs on both lines and occasional enable drops. The reference model finds each bit's entry by summing slice lengths from the frame start, not by stepping counters.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int NUM_CH = 3;
  localparam int STB_W  = 4;
  localparam int CNT_W  = 4;
  localparam int CH_W   = 3;

  // Field order inside a route word (LSB first): last, unit, strobe mask,
  // channel code, length minus one.
  typedef struct packed {
    logic [CNT_W-1:0] cnt_m1;
    logic [CH_W-1:0]  chan;
    logic [STB_W-1:0] stb;
    logic             byte_unit;
    logic             last;
  } route_t;

  localparam int ROUTE_W = $bits(route_t);

  localparam logic [CH_W-1:0] CH0_CODE = 3'b010;
  localparam logic [CH_W-1:0] CH1_CODE = 3'b011;
  localparam logic [CH_W-1:0] CH2_CODE = 3'b101;

  function automatic logic [NUM_CH-1:0] chan_onehot(input logic [CH_W-1:0] code);
    logic [NUM_CH-1:0] oh;
    oh = '0;
    unique case (code)
      CH0_CODE: oh[0] = 1'b1;
      CH1_CODE: oh[1] = 1'b1;
      CH2_CODE: oh[2] = 1'b1;
      default:  oh = '0;
    endcase
    return oh;
  endfunction
endpackage

// File: rtl/tsa_rst_sync.sv
module tsa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/tsa_route_table.sv
module tsa_route_table #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr_a,
  output logic [WORD_W-1:0] rd_data_a,
  input  logic [AW-1:0]     rd_addr_b,
  output logic [WORD_W-1:0] rd_data_b
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data_a = mem_q[rd_addr_a];
  assign rd_data_b = mem_q[rd_addr_b];
endmodule

// File: rtl/tsa_walker.sv
module tsa_walker
  import tsa_pkg::*;
#(
  parameter int AW = 4,
  localparam int POS_W = CNT_W + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          sync,
  input  route_t        entry,
  output logic [AW-1:0] rd_idx,
  output logic          live,
  output logic          overrun
);
  logic             active_q, active_d;
  logic [AW-1:0]    idx_q, idx_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [POS_W-1:0] cur_pos, len_m1;
  logic             at_end;

  // Current position: a sync overrides the stored walk state.
  always_comb begin
    rd_idx  = sync ? '0 : idx_q;
    cur_pos = sync ? '0 : pos_q;
    live    = en & (sync | active_q);
    overrun = en & sync & active_q;
    len_m1  = entry.byte_unit ? {entry.cnt_m1, 3'b111} : POS_W'(entry.cnt_m1);
    at_end  = (cur_pos == len_m1);
  end

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    pos_d    = pos_q;
    if (!en) begin
      active_d = 1'b0;
      idx_d    = '0;
      pos_d    = '0;
    end else if (live) begin
      if (at_end) begin
        active_d = ~entry.last;
        idx_d    = rd_idx + 1'b1;
        pos_d    = '0;
      end else begin
        active_d = 1'b1;
        idx_d    = rd_idx;
        pos_d    = cur_pos + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      pos_q    <= '0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
      pos_q    <= pos_d;
    end
  end
endmodule

// File: rtl/tdm_slot_router.sv
module tdm_slot_router
  import tsa_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     common_mode,
  input  logic                     sync,
  input  logic                     tx_sync,
  input  logic                     rxd,
  input  logic [NUM_CH-1:0]        tx_din,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [WORD_W-1:0]        wr_data,
  output logic                     rx_data,
  output logic [NUM_CH-1:0]        rx_valid,
  output logic                     tx_bit,
  output logic [NUM_CH-1:0]        tx_take,
  output logic [STB_W-1:0]         strobe,
  output logic                     sync_error
);
  localparam int AW = $clog2(DEPTH);

  logic              rst_n_i;
  logic [AW-1:0]     rx_idx, tx_idx, rx_addr, tx_addr;
  logic [WORD_W-1:0] rx_word, tx_word;
  route_t            rx_entry, tx_entry;
  logic              rx_live, tx_live, rx_over, tx_over, tx_sync_sel;

  logic              rx_data_d, tx_bit_d, err_d;
  logic [NUM_CH-1:0] rx_valid_d, tx_take_d;
  logic [STB_W-1:0]  strobe_d;

  tsa_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  tsa_route_table #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_table (
    .clk(clk), .rst_n(rst_n_i),
    .wr_en(wr_en & ~en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr_a(rx_addr), .rd_data_a(rx_word),
    .rd_addr_b(tx_addr), .rd_data_b(tx_word)
  );

  // Split mode: receive in the lower half, transmit in the upper half.
  always_comb begin
    if (common_mode) begin
      rx_addr     = rx_idx;
      tx_addr     = tx_idx;
      tx_sync_sel = sync;
    end else begin
      rx_addr     = {1'b0, rx_idx[AW-2:0]};
      tx_addr     = {1'b1, tx_idx[AW-2:0]};
      tx_sync_sel = tx_sync;
    end
    rx_entry = route_t'(rx_word[ROUTE_W-1:0]);
    tx_entry = route_t'(tx_word[ROUTE_W-1:0]);
  end

  tsa_walker #(.AW(AW)) u_rx_walk (
    .clk(clk), .rst_n(rst_n_i), .en(en), .sync(sync), .entry(rx_entry),
    .rd_idx(rx_idx), .live(rx_live), .overrun(rx_over)
  );

  tsa_walker #(.AW(AW)) u_tx_walk (
    .clk(clk), .rst_n(rst_n_i), .en(en), .sync(tx_sync_sel), .entry(tx_entry),
    .rd_idx(tx_idx), .live(tx_live), .overrun(tx_over)
  );

  always_comb begin
    rx_data_d  = rxd;
    rx_valid_d = rx_live ? chan_onehot(rx_entry.chan) : '0;
    strobe_d   = rx_live ? rx_entry.stb : '0;
    tx_take_d  = tx_live ? chan_onehot(tx_entry.chan) : '0;
    tx_bit_d   = (|tx_take_d) ? |(tx_din & tx_take_d) : 1'b1;
    err_d      = sync_error | rx_over | tx_over;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rx_data    <= 1'b0;
      rx_valid   <= '0;
      strobe     <= '0;
      tx_take    <= '0;
      tx_bit     <= 1'b1;
      sync_error <= 1'b0;
    end else begin
      rx_data    <= rx_data_d;
      rx_valid   <= rx_valid_d;
      strobe     <= strobe_d;
      tx_take    <= tx_take_d;
      tx_bit     <= tx_bit_d;
      sync_error <= err_d;
    end
  end
endmodule

// File: rtl/tsa_checker.sv
module tsa_checker
  import tsa_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [NUM_CH-1:0] tx_din,
  input logic [NUM_CH-1:0] rx_valid,
  input logic [NUM_CH-1:0] tx_take,
  input logic              tx_bit,
  input logic [STB_W-1:0]  strobe,
  input logic              sync_error
);
  assert_valid_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_valid));

  assert_take_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_take));

  assert_tx_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take == '0) |-> tx_bit);

  assert_tx_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take != '0) |-> (tx_bit == |($past(tx_din) & tx_take)));

  assert_error_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_error |=> sync_error);

  assert_quiet_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (rx_valid == '0 && tx_take == '0 && strobe == '0));
endmodule

bind tdm_slot_router tsa_checker u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .tx_din(tx_din),
  .rx_valid(rx_valid), .tx_take(tx_take), .tx_bit(tx_bit),
  .strobe(strobe), .sync_error(sync_error)
);

// File: tb/tdm_slot_router_test.sv
module tdm_slot_router_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en, common_mode, sync, tx_sync, rxd, wr_en;
  logic [2:0]  tx_din;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic        rx_data, tx_bit, sync_error;
  logic [2:0]  rx_valid, tx_take;
  logic [3:0]  strobe;

  int errors = 0, checks = 0;
  bit done = 0;
  string phase = "R10";

  int tbl [16];
  int rx_pend = -1, tx_pend = -1;
  bit m_err = 0;
  logic       e_rxd = 0, e_txb = 1, e_err = 0;
  logic [2:0] e_rxv = 0, e_take = 0;
  logic [3:0] e_stb = 0;
  int n_rxv [3];
  int n_take [3];
  int n_stb [4];

  always #4 clk = ~clk;

  tdm_slot_router uut (
    .clk(clk), .rst_n(rst_n), .en(en), .common_mode(common_mode), .sync(sync),
    .tx_sync(tx_sync), .rxd(rxd), .tx_din(tx_din), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rx_data(rx_data), .rx_valid(rx_valid),
    .tx_bit(tx_bit), .tx_take(tx_take), .strobe(strobe), .sync_error(sync_error)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) %s: actual=%0h expected=%0h", tag, phase, what, act, exp);
    end
  endtask

  function automatic int mk(int cnt, int ch, int stb, int byt, int last);
    return (cnt << 9) | (ch << 6) | (stb << 2) | (byt << 1) | last;
  endfunction

  function automatic int ch_of(int w);
    case ((w >> 6) & 7)
      2: return 0;
      3: return 1;
      5: return 2;
      default: return -1;
    endcase
  endfunction

  function automatic int len_of(int w);
    return (((w >> 9) & 15) + 1) * (((w >> 1) & 1) ? 8 : 1);
  endfunction

  // Entry owning bit offset t of a frame, or -1 when the frame has ended.
  function automatic int locate(int t, int base, int span);
    int acc = 0, ei = 0;
    for (int k = 0; k <= t; k++) begin
      int w = tbl[base + ei];
      if (t < acc + len_of(w)) return base + ei;
      if (w & 1) return -1;
      acc += len_of(w);
      ei = (ei + 1) % span;
    end
    return -1;
  endfunction

  task automatic walk(input bit s, inout int pend, output int e, input int base, input int span);
    int cur;
    if (!en) begin pend = -1; e = -1; return; end
    if (s) begin
      if (pend >= 0) m_err = 1;
      cur = 0;
    end else cur = pend;
    e = (cur >= 0) ? locate(cur, base, span) : -1;
    pend = (e >= 0 && locate(cur + 1, base, span) >= 0) ? cur + 1 : -1;
  endtask

  task automatic model_update();
    int er, et, span, c;
    span = common_mode ? 16 : 8;
    walk(sync, rx_pend, er, 0, span);
    walk(common_mode ? sync : tx_sync, tx_pend, et, common_mode ? 0 : 8, span);
    e_rxd = rxd;
    c = (er >= 0) ? ch_of(tbl[er]) : -1;
    e_rxv = (c >= 0) ? 3'(1 << c) : 3'b0;
    e_stb = (er >= 0) ? 4'((tbl[er] >> 2) & 15) : 4'b0;
    c = (et >= 0) ? ch_of(tbl[et]) : -1;
    e_take = (c >= 0) ? 3'(1 << c) : 3'b0;
    e_txb = (c >= 0) ? tx_din[c] : 1'b1;
    e_err = m_err;
    if (wr_en && !en) tbl[wr_addr] = wr_data;
  endtask

  task automatic compare();
    chk(rx_valid == e_rxv, "R3", "rx_valid", rx_valid, e_rxv);
    chk(rx_data == e_rxd, "R3", "rx_data", rx_data, e_rxd);
    chk(strobe == e_stb, "R4", "strobe", strobe, e_stb);
    chk(tx_take == e_take, "R7", "tx_take", tx_take, e_take);
    chk(tx_bit == e_txb, "R7", "tx_bit", tx_bit, e_txb);
    chk(sync_error == e_err, "R6", "sync_error", sync_error, e_err);
    for (int i = 0; i < 3; i++) begin
      n_rxv[i] += rx_valid[i];
      n_take[i] += tx_take[i];
    end
    for (int i = 0; i < 4; i++) n_stb[i] += strobe[i];
  endtask

  task automatic tick();
    model_update();
    @(negedge clk);
    compare();
  endtask

  task automatic clr();
    for (int i = 0; i < 3; i++) begin n_rxv[i] = 0; n_take[i] = 0; end
    for (int i = 0; i < 4; i++) n_stb[i] = 0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      rxd = 1'($urandom); tx_din = 3'($urandom);
      tick();
    end
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = 4'(a); wr_data = 16'(d);
    tick();
    wr_en = 0;
  endtask

  task automatic pulse_sync();
    sync = 1; rxd = 1'($urandom); tx_din = 3'($urandom);
    tick();
    sync = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; en = 0; common_mode = 1; sync = 0; tx_sync = 0; rxd = 0;
    tx_din = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    for (int i = 0; i < 16; i++) tbl[i] = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(rx_valid == 0 && tx_take == 0 && strobe == 0 && rx_data == 0, "R10", "outputs", {rx_valid, tx_take, strobe}, 0);
    chk(tx_bit == 1 && sync_error == 0, "R10", "tx_bit/err", {tx_bit, sync_error}, 2);
    rst_n = 1;
    repeat (3) tick();

    // Example frame: 8 bits ch0 | 1 bit ch1+strobe0 | 1 none | 4 strobe1 | 4 ch2 | 1 ch1+strobe0 last
    phase = "R2";
    wr(0, mk(0, 2, 0, 1, 0));
    wr(1, mk(0, 3, 1, 0, 0));
    wr(2, mk(0, 0, 0, 0, 0));
    wr(3, mk(3, 0, 2, 0, 0));
    wr(4, mk(3, 5, 0, 0, 0));
    wr(5, mk(0, 3, 1, 0, 1) | 16'he000);
    en = 1; tick();
    clr();
    pulse_sync();
    chk(rx_valid == 3'b001, "R1", "first slice owner", rx_valid, 1);
    run(34);
    chk(n_rxv[0] == 8, "R2", "byte slice bits", n_rxv[0], 8);
    chk(n_rxv[2] == 4, "R2", "4-bit slice bits", n_rxv[2], 4);
    chk(n_rxv[1] == 2, "R3", "ch1 bits", n_rxv[1], 2);
    chk(n_stb[0] == 2 && n_stb[1] == 4, "R4", "strobe bits", {n_stb[0], n_stb[1]}, 24);
    chk(n_take[0] == 8 && n_take[2] == 4, "R8", "common tx follows table", {n_take[0], n_take[2]}, 84);
    chk(rx_valid == 0 && strobe == 0 && tx_take == 0, "R5", "idle after last", {rx_valid, strobe}, 0);
    chk(sync_error == 0, "R6", "no error yet", sync_error, 0);

    phase = "R6";
    pulse_sync();
    run(5);
    pulse_sync();
    chk(sync_error == 1, "R6", "early sync flagged", sync_error, 1);
    chk(rx_valid == 3'b001, "R6", "restart at entry 0", rx_valid, 1);
    run(30);

    phase = "R9";
    wr(0, mk(0, 0, 0, 0, 1));
    clr();
    pulse_sync();
    run(30);
    chk(n_rxv[0] == 8, "R9", "write while enabled ignored", n_rxv[0], 8);

    phase = "R11";
    pulse_sync();
    run(3);
    en = 0; tick();
    chk(rx_valid == 0 && strobe == 0 && tx_take == 0, "R11", "quiet when disabled", {rx_valid, strobe, tx_take}, 0);
    run(3);

    phase = "R8";
    wr(8, mk(1, 2, 0, 1, 0));
    wr(9, mk(2, 5, 0, 0, 1));
    common_mode = 0; en = 1; tick();
    clr();
    tx_sync = 1; tick(); tx_sync = 0;
    run(2);
    pulse_sync();
    run(30);
    chk(n_take[0] == 16 && n_take[2] == 3 && n_take[1] == 0, "R8", "split tx half", {n_take[0], n_take[1], n_take[2]}, 'h1003);
    chk(n_rxv[0] == 8 && n_rxv[2] == 4, "R8", "split rx half", {n_rxv[0], n_rxv[2]}, 84);

    phase = "R2 random";
    for (int blk = 0; blk < 40; blk++) begin
      en = 0; tick();
      for (int k = 0; k < 4; k++) wr($urandom % 16, $urandom);
      common_mode = 1'($urandom);
      en = 1;
      for (int i = 0; i < 150; i++) begin
        sync = ($urandom % 40) == 0;
        tx_sync = ($urandom % 40) == 0;
        wr_en = ($urandom % 10) == 0; wr_addr = 4'($urandom); wr_data = 16'($urandom);
        rxd = 1'($urandom); tx_din = 3'($urandom);
        tick();
      end
      sync = 0; tx_sync = 0; wr_en = 0;
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule